// File: doc/BRIEF.md
# Hardware Cursor and Crosshair Overlay Generator

This block sits beside the video raster and, one pixel per clock, decides whether the current pixel is covered by a 64x64 two-plane cursor bitmap, by a crosshair, or by both. It returns two plane bits per pixel. Later logic uses these bits to pick overlay colours. The raster position arrives as horizontal and vertical counters in screen coordinates. The command value, cursor position and crosshair window are static inputs. The bitmap is read from an external synchronous RAM through a read port that this block addresses.

The cursor position is written in an offset frame that absorbs pipeline and sync delays. The bitmap origin on screen is the programmed position minus a horizontal offset and minus a vertical offset. The horizontal offset depends on the pixel multiplex mode. A crosshair of selectable thickness passes through the bitmap centre and is clipped to a rectangular window. When both sources are enabled, their outputs are merged by OR or by AND.

Top module: `curs_ovl_top`

## Requirements
- R1: The bitmap origin is ox = pos_x - hoff and oy = pos_y - 36, both modulo 4096. A raster pixel (x, y) lies inside the bitmap when col = (x - ox) mod 4096 < 64 and row = (y - oy) mod 4096 < 64. For such a pixel, bm_addr = row*8 + col/8 in the same cycle as the raster inputs.
- R2: Inside the bitmap, ovl_plane[1] is bit (15 - col%8) of the RAM word and ovl_plane[0] is bit (7 - col%8), so bit 7 of each byte is the leftmost pixel.
- R3: hoff is 37 when ctrl[3:2] = 00, 52 when it is 01 and 57 when it is 10.
- R4: Outside the 64x64 area, the bitmap contributes 0 to both planes.
- R5: When ctrl[5] is set, a pixel is on the crosshair if |x - (ox+32)| <= t or |y - (oy+32)| <= t, where t = ctrl[1:0] (giving widths of 1, 3, 5 or 7 pixels), and if (x - win_x) mod 4096 < win_w and (y - win_y) mod 4096 < win_h. A crosshair pixel drives both planes to 1.
- R6: When win_w or win_h is zero, no crosshair pixel is produced.
- R7: ctrl[6] enables the bitmap. When ctrl[6] and ctrl[5] are both clear, ovl_plane is 0 on every pixel.
- R8: When both sources are enabled, ctrl[4] = 1 ORs the bitmap planes with the crosshair bit and ctrl[4] = 0 ANDs them. When only one source is enabled, that source passes unchanged.
- R9: When ctrl[3:2] = 11 (reserved), ovl_plane is 0.
- R10: When pix_act is low, ovl_plane is 0 for that pixel.
- R11: The raster and control inputs sampled at clock edge k set ovl_plane after edge k+1. bm_rdata is expected one edge after bm_addr.
- R12: While rst_n is low, ovl_plane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_act | input | 1 | Raster is in active video |
| ras_x | input | 12 | Horizontal raster counter |
| ras_y | input | 12 | Vertical raster counter |
| ctrl | input | 7 | Command: [6] bitmap on, [5] crosshair on, [4] OR/AND, [3:2] mux mode, [1:0] thickness |
| pos_x | input | 12 | Programmed cursor x (offset frame) |
| pos_y | input | 12 | Programmed cursor y (offset frame) |
| win_x | input | 12 | Crosshair window left edge |
| win_y | input | 12 | Crosshair window top edge |
| win_w | input | 12 | Crosshair window width |
| win_h | input | 12 | Crosshair window height |
| bm_addr | output | 9 | Bitmap RAM word address {row, col/8} |
| bm_rdata | input | 16 | Bitmap RAM word, high byte mask plane, low byte data plane |
| ovl_plane | output | 2 | Cursor plane bits for the pixel |

## Verification
The bench keeps the default parameters: a 12-bit coordinate space, a 64-pixel bitmap, 8 pixels per byte, and offsets of 37/52/57 horizontally and 36 vertically. Because the coordinates are only 12 bits wide, a cursor whose origin wraps below zero can be placed near the screen edge, which exercises the modulo arithmetic of the hit test. With these offsets, the same screen origin can be reached in each of the three valid mux modes, and every crosshair thickness can be seen within a few scan lines around the bitmap centre.

// File: rtl/curs_pkg.sv
package curs_pkg;

  typedef enum logic [1:0] {
    MUX_1TO1 = 2'b00,
    MUX_4TO1 = 2'b01,
    MUX_5TO1 = 2'b10,
    MUX_RSVD = 2'b11
  } mux_e;

  // Command layout; bit positions are decoded by software-visible encoding.
  typedef struct packed {
    logic       bm_en;    // [6]
    logic       xh_en;    // [5]
    logic       or_mode;  // [4]
    mux_e       mux;      // [3:2]
    logic [1:0] thick;    // [1:0]
  } ctrl_t;

endpackage

// File: rtl/curs_geom.sv
// Bitmap hit test and RAM address generation (combinational).
module curs_geom
  import curs_pkg::*;
#(
  parameter int CW    = 12,
  parameter int DIM   = 64,
  parameter int PW    = 8,
  parameter int HOFF1 = 37,
  parameter int HOFF4 = 52,
  parameter int HOFF5 = 57,
  parameter int VOFF  = 36,
  localparam int CB   = $clog2(DIM),
  localparam int SB   = $clog2(PW),
  localparam int AW   = 2 * CB - SB
) (
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  mux_e          mux,
  output logic [CW-1:0] org_x,
  output logic [CW-1:0] org_y,
  output logic [AW-1:0] addr,
  output logic [SB-1:0] sub,
  output logic          hit
);

  // Horizontal delay compensation per multiplex mode.
  function automatic logic [CW-1:0] mux_offset(input mux_e m);
    logic [CW-1:0] r;
    unique case (m)
      MUX_4TO1: r = CW'(HOFF4);
      MUX_5TO1: r = CW'(HOFF5);
      default:  r = CW'(HOFF1);
    endcase
    return r;
  endfunction

  // Distance from origin in wrapping coordinate space.
  function automatic logic [CW-1:0] wrap_dist(input logic [CW-1:0] p,
                                              input logic [CW-1:0] o);
    return p - o;
  endfunction

  logic [CW-1:0] dx, dy;

  always_comb begin
    org_x = pos_x - mux_offset(mux);
    org_y = pos_y - CW'(VOFF);
    dx    = wrap_dist(ras_x, org_x);
    dy    = wrap_dist(ras_y, org_y);
    hit   = (dx < CW'(DIM)) && (dy < CW'(DIM));
    addr  = {dy[CB-1:0], dx[CB-1:SB]};
    sub   = dx[SB-1:0];
  end

endmodule

// File: rtl/curs_xhair.sv
// Crosshair line test clipped to a window (combinational).
module curs_xhair #(
  parameter int CW  = 12,
  parameter int DIM = 64
) (
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] win_x,
  input  logic [CW-1:0] win_y,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  input  logic [1:0]    thick,
  output logic          on
);

  // True when a signed wrap distance has magnitude at most half.
  function automatic logic near_line(input logic [CW-1:0] d,
                                     input logic [CW-1:0] half);
    logic [CW-1:0] neg;
    neg = CW'(0) - d;
    return (d <= half) || (neg <= half);
  endfunction

  function automatic logic in_span(input logic [CW-1:0] p,
                                   input logic [CW-1:0] base,
                                   input logic [CW-1:0] len);
    logic [CW-1:0] d;
    d = p - base;
    return d < len;
  endfunction

  logic [CW-1:0] ctr_x, ctr_y, half;
  logic          on_line, in_win;

  always_comb begin
    ctr_x   = org_x + CW'(DIM / 2);
    ctr_y   = org_y + CW'(DIM / 2);
    half    = CW'(thick);
    on_line = near_line(ras_x - ctr_x, half) || near_line(ras_y - ctr_y, half);
    in_win  = in_span(ras_x, win_x, win_w) && in_span(ras_y, win_y, win_h);
    on      = on_line && in_win;
  end

endmodule

// File: rtl/curs_mix.sv
// Pipeline stage aligned with RAM latency, bit select and source merge.
module curs_mix #(
  parameter int PW  = 8,
  localparam int SB = $clog2(PW),
  localparam int WW = 2 * PW,
  localparam int IW = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          bm_en,
  input  logic          xh_en,
  input  logic          or_mode,
  input  logic          rsvd,
  input  logic          in_bm,
  input  logic [SB-1:0] sub,
  input  logic          xh,
  input  logic [WW-1:0] rdata,
  output logic [1:0]    plane
);

  logic          act_q, bm_en_q, xh_en_q, or_q, rsvd_q, in_bm_q, xh_q;
  logic [SB-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      bm_en_q <= 1'b0;
      xh_en_q <= 1'b0;
      or_q    <= 1'b0;
      rsvd_q  <= 1'b0;
      in_bm_q <= 1'b0;
      xh_q    <= 1'b0;
      sub_q   <= '0;
    end else begin
      act_q   <= act;
      bm_en_q <= bm_en;
      xh_en_q <= xh_en;
      or_q    <= or_mode;
      rsvd_q  <= rsvd;
      in_bm_q <= in_bm;
      xh_q    <= xh;
      sub_q   <= sub;
    end
  end

  logic [IW-1:0] lo_idx, hi_idx;
  logic [1:0]    bm_bits, xh_bits, merged, nxt;

  always_comb begin
    lo_idx  = IW'(PW - 1) - IW'(sub_q);
    hi_idx  = lo_idx + IW'(PW);
    bm_bits = in_bm_q ? {rdata[hi_idx], rdata[lo_idx]} : 2'b00;
    xh_bits = {2{xh_q}};
    if (bm_en_q && xh_en_q)
      merged = or_q ? (bm_bits | xh_bits) : (bm_bits & xh_bits);
    else if (bm_en_q)
      merged = bm_bits;
    else if (xh_en_q)
      merged = xh_bits;
    else
      merged = 2'b00;
    nxt = (act_q && !rsvd_q) ? merged : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) plane <= 2'b00;
    else        plane <= nxt;
  end

  // Event wire: AND merge with crosshair absent on a live pixel.
  logic and_miss;
  assign and_miss = act_q && !rsvd_q && bm_en_q && xh_en_q && !or_q && !xh_q;

  AST_AND_NEEDS_XH: assert property (@(posedge clk) disable iff (!rst_n)
    and_miss |=> (plane == 2'b00)); // R8

endmodule

// File: rtl/curs_ovl_top.sv
module curs_ovl_top
  import curs_pkg::*;
#(
  parameter int CW    = 12,
  parameter int DIM   = 64,
  parameter int PW    = 8,
  parameter int HOFF1 = 37,
  parameter int HOFF4 = 52,
  parameter int HOFF5 = 57,
  parameter int VOFF  = 36,
  localparam int CB   = $clog2(DIM),
  localparam int SB   = $clog2(PW),
  localparam int AW   = 2 * CB - SB,
  localparam int WW   = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_act,
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [6:0]    ctrl,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] win_x,
  input  logic [CW-1:0] win_y,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  output logic [AW-1:0] bm_addr,
  input  logic [WW-1:0] bm_rdata,
  output logic [1:0]    ovl_plane
);

  ctrl_t         cmd;
  logic [CW-1:0] org_x, org_y;
  logic [SB-1:0] sub;
  logic          bm_hit, xh_hit;

  assign cmd = ctrl_t'(ctrl);

  curs_geom #(
    .CW(CW), .DIM(DIM), .PW(PW),
    .HOFF1(HOFF1), .HOFF4(HOFF4), .HOFF5(HOFF5), .VOFF(VOFF)
  ) u_geom (
    .ras_x(ras_x), .ras_y(ras_y), .pos_x(pos_x), .pos_y(pos_y),
    .mux(cmd.mux), .org_x(org_x), .org_y(org_y),
    .addr(bm_addr), .sub(sub), .hit(bm_hit)
  );

  curs_xhair #(.CW(CW), .DIM(DIM)) u_xhair (
    .ras_x(ras_x), .ras_y(ras_y), .org_x(org_x), .org_y(org_y),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .thick(cmd.thick), .on(xh_hit)
  );

  curs_mix #(.PW(PW)) u_mix (
    .clk(clk), .rst_n(rst_n), .act(pix_act),
    .bm_en(cmd.bm_en), .xh_en(cmd.xh_en), .or_mode(cmd.or_mode),
    .rsvd(cmd.mux == MUX_RSVD), .in_bm(bm_hit), .sub(sub), .xh(xh_hit),
    .rdata(bm_rdata), .plane(ovl_plane)
  );

  // Cycles since reset, saturating, so two-deep history is always valid.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd2)  age <= age + 2'd1;
  end

  logic hist_ok;
  assign hist_ok = (age == 2'd2);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(ctrl[6:5], 2) == 2'b00) |-> (ovl_plane == 2'b00)); // R7

  AST_QUIET_RSVD_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(ctrl[3:2], 2) == 2'b11) |-> (ovl_plane == 2'b00)); // R9

  AST_QUIET_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(pix_act, 2)) |-> (ovl_plane == 2'b00)); // R10

  AST_NO_XH_EMPTY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(!ctrl[6] && (win_w == '0 || win_h == '0), 2))
      |-> (ovl_plane == 2'b00)); // R6

  AST_BM_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(!ctrl[5] && !bm_hit, 2)) |-> (ovl_plane == 2'b00)); // R4

endmodule

// File: tb/tb_curs_ovl_top.sv
module tb_curs_ovl_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_act;
  logic [11:0] ras_x, ras_y, pos_x, pos_y, win_x, win_y, win_w, win_h;
  logic [6:0]  ctrl;
  logic [8:0]  bm_addr;
  logic [15:0] bm_rdata;
  logic [1:0]  ovl_plane;

  always #4 clk = ~clk;

  curs_ovl_top dut (
    .clk(clk), .rst_n(rst_n), .pix_act(pix_act), .ras_x(ras_x), .ras_y(ras_y),
    .ctrl(ctrl), .pos_x(pos_x), .pos_y(pos_y), .win_x(win_x), .win_y(win_y),
    .win_w(win_w), .win_h(win_h), .bm_addr(bm_addr), .bm_rdata(bm_rdata),
    .ovl_plane(ovl_plane)
  );

  logic [15:0] mem [512];
  always @(posedge clk) bm_rdata <= mem[bm_addr];

  int n_chk = 0;
  int n_fail = 0;

  // Current configuration applied by the driver.
  logic        c_act;
  logic [6:0]  c_ctrl;
  int          c_px, c_py, c_wx, c_wy, c_ww, c_wh;

  typedef struct {
    logic [1:0] e;
    string      tag;
  } item_t;
  item_t sb[$];

  function automatic int wrap(int a);
    return ((a % 4096) + 4096) % 4096;
  endfunction

  function automatic int sdist(int a);
    int w;
    w = wrap(a);
    return (w > 2047) ? (4096 - w) : w;
  endfunction

  function automatic int hoff_of(int m);
    if (m == 1) return 52;
    if (m == 2) return 57;
    return 37;
  endfunction

  function automatic logic [1:0] model(int h, int v);
    int m, col, row, t;
    logic [15:0] w;
    logic [1:0] bm, xh;
    logic bon, xon, xin;
    m = int'(c_ctrl[3:2]);
    if (!c_act || m == 3) return 2'b00;
    col = wrap(h - c_px + hoff_of(m));
    row = wrap(v - c_py + 36);
    bm = 2'b00;
    if (col < 64 && row < 64) begin
      w = mem[row * 8 + col / 8];
      bm = {w[15 - (col % 8)], w[7 - (col % 8)]};
    end
    t = int'(c_ctrl[1:0]);
    xin = (wrap(h - c_wx) < c_ww) && (wrap(v - c_wy) < c_wh);
    xon = xin && ((sdist(col - 32) <= t) || (sdist(row - 32) <= t));
    xh = {xon, xon};
    bon = c_ctrl[6];
    if (bon && c_ctrl[5]) return c_ctrl[4] ? (bm | xh) : (bm & xh);
    if (bon) return bm;
    if (c_ctrl[5]) return xh;
    return 2'b00;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one raster pixel and push its expected result.
  task automatic step(int h, int v, string tag, bit chk_addr = 0);
    item_t it;
    int col, row;
    @(negedge clk);
    pix_act = c_act; ctrl = c_ctrl;
    pos_x = 12'(c_px); pos_y = 12'(c_py);
    win_x = 12'(c_wx); win_y = 12'(c_wy);
    win_w = 12'(c_ww); win_h = 12'(c_wh);
    ras_x = 12'(h); ras_y = 12'(v);
    it.e = model(h, v);
    it.tag = tag;
    sb.push_back(it);
    if (chk_addr) begin
      col = wrap(h - c_px + hoff_of(int'(c_ctrl[3:2])));
      row = wrap(v - c_py + 36);
      if (col < 64 && row < 64) begin
        #1;
        check("R1 addr", 16'(bm_addr), 16'(row * 8 + col / 8));
      end
    end
  endtask

  // Monitor: compare results two cycles after their inputs.
  always @(negedge clk) begin
    item_t it;
    #1;
    if (sb.size() >= 3) begin
      it = sb.pop_front();
      check(it.tag, 16'(ovl_plane), 16'(it.e));
    end
  end

  task automatic scan(int v, int h0, int h1, string tag, bit chk_addr = 0);
    for (int h = h0; h <= h1; h++) step(h, v, tag, chk_addr);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++)
      mem[i] = 16'((i * 40503) ^ (i << 3) ^ 23100);
    c_act = 1'b1; c_ctrl = 7'h44;
    c_px = 152; c_py = 86; c_wx = 0; c_wy = 0; c_ww = 4095; c_wh = 4095;
    rst_n = 1'b0; pix_act = 1'b1; ctrl = 7'h7F;
    pos_x = 12'd152; pos_y = 12'd86; win_x = 0; win_y = 0;
    win_w = 12'd4095; win_h = 12'd4095; ras_x = 12'd110; ras_y = 12'd60;
    repeat (4) @(negedge clk);
    check("R12 reset", 16'(ovl_plane), 16'h0);
    rst_n = 1'b1;

    // R1 R2 R4: bitmap only, 4:1 mode, origin (100,50)
    c_ctrl = 7'h44;
    scan(49, 96, 166, "R4 above");
    scan(50, 96, 166, "R2 first row", 1);
    scan(77, 96, 166, "R1 mid row", 1);
    scan(113, 96, 166, "R1 last row", 1);
    scan(114, 96, 166, "R4 below");

    // R3: other mux modes reach same origin
    c_ctrl = 7'h40; c_px = 137;
    scan(60, 96, 166, "R3 1to1", 1);
    c_ctrl = 7'h48; c_px = 157;
    scan(60, 96, 166, "R3 5to1", 1);
    c_ctrl = 7'h44; c_px = 20;
    scan(60, 0, 40, "R3 wrap origin", 1);

    // R5: crosshair thickness 1,3,5,7, full window
    c_px = 152; c_py = 86;
    for (int t = 0; t < 4; t++) begin
      c_ctrl = 7'(7'h24 | t);
      for (int v = 78; v <= 86; v++) scan(v, 124, 140, "R5 thickness");
    end
    // R5: window clipping
    c_ctrl = 7'h27; c_wx = 120; c_wy = 80; c_ww = 14; c_wh = 3;
    for (int v = 77; v <= 84; v++) scan(v, 115, 140, "R5 window");

    // R6: empty window
    c_ww = 0; c_wh = 4095; c_wx = 0; c_wy = 0;
    scan(82, 120, 145, "R6 zero width");
    c_ww = 4095; c_wh = 0;
    scan(82, 120, 145, "R6 zero height");
    c_wh = 4095;

    // R8: merge modes and single-source pass-through
    c_ctrl = 7'h75;
    foreach (sb[i]) ;
    scan(52, 96, 166, "R8 OR");
    scan(82, 96, 166, "R8 OR");
    c_ctrl = 7'h65;
    scan(52, 96, 166, "R8 AND");
    scan(82, 96, 166, "R8 AND");
    c_ctrl = 7'h55;
    scan(82, 96, 166, "R8 bitmap only");

    // R7, R9, R10, R11
    c_ctrl = 7'h17;
    scan(82, 96, 166, "R7 disabled");
    c_ctrl = 7'h7C;
    scan(82, 96, 166, "R9 reserved");
    c_ctrl = 7'h74; c_act = 1'b0;
    scan(82, 96, 166, "R10 blank");
    for (int h = 96; h <= 166; h++) begin
      c_act = h[0];
      step(h, 70, "R11 alternating");
    end
    c_act = 1'b1;
    for (int h = 166; h >= 96; h--) step(h, 90, "R11 reverse scan");

    repeat (3) step(0, 0, "flush");
    @(negedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule